// File: doc/BRIEF.md
# Atomic Lock Memory

A small register-based shared memory that several requesters reach through their own ports. Each port can issue a plain load, a plain store, an exchange, or a test-and-set. An arbiter accepts at most one port per clock. The accepted operation reads the addressed word and writes its new value in that same clock slot, so no other access can come between the read and the write. Every accepted operation returns the old contents of the word to the port that issued it, one cycle later.

Software builds spin locks on top of this. A requester runs test-and-set on a lock word. A returned 0 means the lock was free and now belongs to that requester. Any other value means the lock is taken and the requester retries. The holder frees the lock with a plain store of 0. Port priority is set by a parameter: either a rotating order that starts just after the last accepted port, or a fixed order in which port 0 ranks highest.

Top module: `atomic_lock_mem`

## Requirements
- R1: While reset is high, `req_ready` and `rsp_valid` are all 0. After reset, every word of the memory reads 0.
- R2: In each cycle at most one bit of `req_ready` is 1, and it is 1 only on a port whose `req_valid` is 1. When any port is valid, one port is made ready.
- R3: A load (op code 0) returns the addressed word and leaves the memory unchanged.
- R4: A store (op code 1) writes `req_wdata` into the addressed word and returns the word's previous contents.
- R5: An exchange (op code 2) returns the previous contents of the word and writes `req_wdata` into it, as one indivisible step.
- R6: A test-and-set (op code 3) returns the previous contents of the word and writes the value 1 into it, as one indivisible step.
- R7: When several ports run test-and-set on the same word while it holds 0, exactly one of them receives 0. The others receive a nonzero value.
- R8: After a store of 0 to a lock word, the next test-and-set on that word returns 0.
- R9: With `RR`=1, the accepted port is the first valid port in circular order after the last accepted port (port 0 comes first after reset). A port that holds its request is accepted within N cycles.
- R10: With `RR`=0, the lowest-numbered valid port is accepted.
- R11: `rsp_valid[i]` is 1 for exactly one cycle, the cycle after port i was accepted. In that cycle, `rsp_data` slice i holds the value that operation returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N | Request present, one bit per port |
| req_ready | output | N | Request accepted this cycle, one bit per port |
| req_op | input | 2*N | Op code per port (slice i at bits 2i+1:2i): 0 load, 1 store, 2 exchange, 3 test-and-set |
| req_addr | input | N*AW | Word address per port |
| req_wdata | input | N*DW | Value written by store and exchange, per port |
| rsp_valid | output | N | Response present, one bit per port |
| rsp_data | output | N*DW | Old word contents returned, per port |

## Verification
`req_ready` is combinational, so the bench drives requests at the falling edge and reads the grant 1 ns later, in the same cycle. It checks that grant against the priority order it models itself. The memory update and the response take effect at the next rising edge, so each response is checked at the following falling edge against the value the bench's own memory model predicted when the request was accepted. The lock results (exactly one zero from a contention burst, and a zero after release) are collected from those responses only after the last response of the burst has arrived.

// File: rtl/atomic_lock_mem.sv
`timescale 1ns/1ps
module atomic_lock_mem #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int RR = 1
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_valid,
  output logic [N-1:0]    req_ready,
  input  logic [2*N-1:0]  req_op,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  output logic [N-1:0]    rsp_valid,
  output logic [N*DW-1:0] rsp_data
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_SWAP  = 2'd2;
  localparam logic [1:0] OP_TAS   = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] last, sel;
  logic [N-1:0]  gnt;
  logic          hit;

  always_comb begin
    int j;
    gnt = '0;
    sel = '0;
    hit = 1'b0;
    j   = 0;
    for (int k = 0; k < N; k++) begin
      j = (RR != 0) ? (int'(last) + 1 + k) % N : k;
      if (!hit && req_valid[j]) begin
        hit    = 1'b1;
        sel    = PW'(j);
        gnt[j] = 1'b1;
      end
    end
  end

  assign req_ready = rst ? '0 : gnt;

  logic [1:0]    op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, old, newv;

  assign op    = req_op[int'(sel)*2 +: 2];
  assign addr  = req_addr[int'(sel)*AW +: AW];
  assign wdata = req_wdata[int'(sel)*DW +: DW];
  assign old   = mem[addr];

  always_comb begin
    case (op)
      OP_LOAD:  newv = old;
      OP_STORE: newv = wdata;
      OP_SWAP:  newv = wdata;
      OP_TAS:   newv = DW'(1);
      default:  newv = old;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
      last      <= PW'(N - 1);
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= gnt;
      if (hit) begin
        mem[addr]                     <= newv;
        rsp_data[int'(sel)*DW +: DW]  <= old;
        last                          <= sel;
      end
    end
  end
endmodule

// File: rtl/atomic_lock_mem_chk.sv
`timescale 1ns/1ps
module atomic_lock_mem_chk #(
  parameter int N  = 4,
  parameter int RR = 1
)(
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_valid,
  input logic [N-1:0] req_ready,
  input logic [N-1:0] rsp_valid
);
  p_one_ready_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(req_ready));
  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (rst) (req_ready & ~req_valid) == '0);
  p_work_conserving_r2: assert property (@(posedge clk) disable iff (rst) (req_valid != '0) |-> (req_ready != '0));
  p_rsp_after_accept_r11: assert property (@(posedge clk) disable iff (rst) rsp_valid == $past(req_ready));

  generate
    if (RR != 0) begin : g_fair
      for (genvar i = 0; i < N; i++) begin : g_port
        int wait_cnt;
        always_ff @(posedge clk) begin
          if (rst) wait_cnt <= 0;
          else if (req_valid[i] && !req_ready[i]) wait_cnt <= wait_cnt + 1;
          else wait_cnt <= 0;
        end
        p_no_starve_r9: assert property (@(posedge clk) disable iff (rst) wait_cnt < N);
      end
    end
  endgenerate
endmodule

bind atomic_lock_mem atomic_lock_mem_chk #(.N(N), .RR(RR)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/atomic_lock_mem_bench.sv
`timescale 1ns/1ps
module atomic_lock_mem_bench;
  localparam int N = 4, AW = 4, DW = 32, DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0] req_valid, req_ready, rsp_valid, fp_ready, fp_rv;
  logic [2*N-1:0] req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata, rsp_data, fp_rd;

  atomic_lock_mem #(.N(N), .AW(AW), .DW(DW), .RR(1)) u_atomic_lock_mem (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data));
  atomic_lock_mem #(.N(N), .AW(AW), .DW(DW), .RR(0)) u_atomic_lock_mem_fp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(fp_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(fp_rv), .rsp_data(fp_rd));

  logic          dv [N];
  logic [1:0]    dop [N];
  logic [AW-1:0] dad [N];
  logic [DW-1:0] dwd [N];
  logic          nv [N];
  logic [1:0]    nop [N];
  logic [AW-1:0] nad [N];
  logic [DW-1:0] nwd [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]             = dv[i];
      req_op[i*2 +: 2]         = dop[i];
      req_addr[i*AW +: AW]     = dad[i];
      req_wdata[i*DW +: DW]    = dwd[i];
    end
  end

  logic [DW-1:0] mdl [DEPTH];
  int ptr;
  logic          exp_rv [N];
  logic [DW-1:0] exp_rd [N];
  logic [1:0]    exp_op [N];
  logic          acc [N];
  logic [DW-1:0] got_d [N];
  int checks = 0, failures = 0;
  int zero_cnt = 0, rsp_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic string op_req(input logic [1:0] o);
    case (o)
      2'd0: return "R3 load";
      2'd1: return "R4 store";
      2'd2: return "R5 exchange";
      default: return "R6 test-and-set";
    endcase
  endfunction

  function automatic logic [DW-1:0] next_val(input logic [1:0] o, input logic [DW-1:0] oldv, input logic [DW-1:0] w);
    case (o)
      2'd0: return oldv;
      2'd3: return DW'(1);
      default: return w;
    endcase
  endfunction

  function automatic int rr_pick();
    for (int k = 0; k < N; k++) begin
      int j = (ptr + 1 + k) % N;
      if (dv[j]) return j;
    end
    return -1;
  endfunction

  function automatic int fp_pick();
    for (int k = 0; k < N; k++) if (dv[k]) return k;
    return -1;
  endfunction

  task automatic step();
    int g, f;
    logic [N-1:0] eg, ef;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(rsp_valid[i] == exp_rv[i], "R11 rsp_valid", 64'(rsp_valid[i]), 64'(exp_rv[i]));
      if (exp_rv[i] && rsp_valid[i]) begin
        chk(rsp_data[i*DW +: DW] == exp_rd[i], op_req(exp_op[i]), 64'(rsp_data[i*DW +: DW]), 64'(exp_rd[i]));
        got_d[i] = rsp_data[i*DW +: DW];
        rsp_cnt++;
        if (rsp_data[i*DW +: DW] == '0) zero_cnt++;
      end
      exp_rv[i] = 1'b0;
      acc[i] = 1'b0;
      dv[i] = nv[i]; dop[i] = nop[i]; dad[i] = nad[i]; dwd[i] = nwd[i];
    end
    #1;
    g = rr_pick();
    f = fp_pick();
    eg = (g < 0) ? '0 : N'(1) << g;
    ef = (f < 0) ? '0 : N'(1) << f;
    chk(req_ready == eg, "R9 R2 rotating grant", 64'(req_ready), 64'(eg));
    chk(fp_ready == ef, "R10 fixed grant", 64'(fp_ready), 64'(ef));
    if (g >= 0) begin
      exp_rv[g] = 1'b1;
      exp_rd[g] = mdl[dad[g]];
      exp_op[g] = dop[g];
      mdl[dad[g]] = next_val(dop[g], mdl[dad[g]], dwd[g]);
      ptr = g;
      acc[g] = 1'b1;
    end
  endtask

  task automatic clear_accepted();
    for (int i = 0; i < N; i++) if (acc[i]) nv[i] = 1'b0;
  endtask

  task automatic put(input int p, input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
    nv[p] = 1'b1; nop[p] = o; nad[p] = a; nwd[p] = w;
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    ptr = N - 1;
    for (int a = 0; a < DEPTH; a++) mdl[a] = '0;
    for (int i = 0; i < N; i++) begin
      exp_rv[i] = 0; exp_rd[i] = '0; exp_op[i] = '0; acc[i] = 0; got_d[i] = '1;
      dv[i] = 1'b1; dop[i] = 2'd0; dad[i] = AW'(i); dwd[i] = '0;
      nv[i] = 1'b0; nop[i] = 2'd0; nad[i] = '0; nwd[i] = '0;
    end
    repeat (3) begin
      @(negedge clk);
      chk(req_ready == '0, "R1 ready in reset", 64'(req_ready), 64'd0);
      chk(rsp_valid == '0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    end
    for (int i = 0; i < N; i++) dv[i] = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < N; i++) put(i, 2'd0, AW'(i + 8), '0);
    repeat (5) begin step(); clear_accepted(); end
    for (int i = 0; i < N; i++) chk(got_d[i] == '0, "R1 memory zero after reset", 64'(got_d[i]), 64'd0);

    put(0, 2'd1, AW'(5), 32'd0);
    repeat (2) begin step(); clear_accepted(); end
    zero_cnt = 0; rsp_cnt = 0;
    for (int i = 0; i < N; i++) put(i, 2'd3, AW'(5), '0);
    repeat (5) begin step(); clear_accepted(); end
    chk(rsp_cnt == N, "R7 responses from contenders", 64'(rsp_cnt), 64'(N));
    chk(zero_cnt == 1, "R7 exactly one winner", 64'(zero_cnt), 64'd1);

    put(3, 2'd1, AW'(5), 32'd0);
    repeat (2) begin step(); clear_accepted(); end
    put(1, 2'd3, AW'(5), '0);
    repeat (2) begin step(); clear_accepted(); end
    chk(got_d[1] == '0, "R8 lock free after release", 64'(got_d[1]), 64'd0);
    put(2, 2'd3, AW'(5), '0);
    repeat (2) begin step(); clear_accepted(); end
    chk(got_d[2] == DW'(1), "R6 lock now held", 64'(got_d[2]), 64'd1);

    put(2, 2'd2, AW'(6), 32'hA5A5);
    repeat (2) begin step(); clear_accepted(); end
    put(0, 2'd2, AW'(6), 32'h1);
    repeat (2) begin step(); clear_accepted(); end
    chk(got_d[0] == 32'hA5A5, "R5 exchange old value", 64'(got_d[0]), 64'hA5A5);

    for (int c = 0; c < 2000; c++) begin
      for (int i = 0; i < N; i++)
        if (!nv[i] && ($urandom % 3) == 0)
          put(i, 2'($urandom % 4), AW'($urandom % 4), DW'($urandom % 3));
      step();
      clear_accepted();
    end
    for (int i = 0; i < N; i++) nv[i] = 1'b0;
    repeat (2) step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule